// File: doc/BRIEF.md
# Four-Channel Multi-Mode Counter/Timer Bank

This block holds four independent 16-bit counters that share one clock prescaler. A single configuration write selects a channel and sets its operating mode, its count direction, the source of its control input, and a preload value. The same write copies the preload into the running count and arms the channel. There are five modes. A one-shot pulse timer stops at terminal count. A waveform timer reloads at terminal count and keeps going. An event counter steps on control-input edges. A capture timer runs freely and snapshots its count on an edge. A watchdog must be reloaded by software before it expires.

Each channel has a control input. It can come from an internal logic net or from a dedicated pin. Depending on the mode it gates counting or triggers an action. Each channel keeps a sticky terminal-count flag, and all four flags go to an interrupt controller. One channel, chosen by parameter, drives a watchdog output back into the surrounding logic. A simple read port returns the running count and the capture register of any channel.

Top module: `ctmr_bank`

## Requirements
- R1: After a prescaler write of value V, the prescaled tick repeats every D clock cycles. D is V, limited to the range 4 to 280: values below 4 give 4 and values above 280 give 280. The write restarts the prescaler phase. After reset D is 4.
- R2: A configuration write loads `cfg_preload` into the selected channel's count, arms that channel, and latches its mode, direction and source. Other channels are left untouched.
- R3: In mode 0 (pulse), an armed channel moves one step per tick while its control level is high and holds while it is low. On the first tick that finds the count at terminal (0x0000 counting down, 0xFFFF counting up), the channel sets its flag and stops. It then holds until the next configuration write.
- R4: In mode 1 (waveform), counting is gated as in pulse mode. A tick that finds the count at terminal reloads the preload, sets the flag, and leaves the channel running.
- R5: In mode 2 (event), the count steps once for each rising edge of the control input, whatever the prescaler is doing. An edge that finds the count at terminal reloads the preload and sets the flag.
- R6: In mode 3 (capture), the count steps on every tick regardless of the control level and wraps at the top and bottom. A rising control edge copies the count as it stood before that clock edge into the channel's capture register and sets the flag.
- R7: In mode 4 (watchdog), the control input has no effect. A tick that finds the count at terminal sets the flag and reloads the preload. On the watchdog channel (channel 3 by default), that tick also raises `wdog_out`, which stays high until the next tick. A configuration write (the software reload) drops `wdog_out` at once.
- R8: `cfg_src_pin` = 1 takes the channel's control from `ctl_pin[i]`. A value of 0 takes it from `ctl_logic[i]`. The source that is not selected has no effect on the count, the capture register or the flag.
- R9: Flag bit i of `tc_flag` belongs to channel i. It stays set until `flag_clr[i]` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R10: After synchronous reset, all counts, captures, flags and `wdog_out` read 0. Every channel is disarmed in pulse mode, counting up, with its control taken from logic.
- R11: `cfg_down` = 1 makes a channel decrement and `cfg_down` = 0 makes it increment. The terminal value follows the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_we | input | 1 | Prescaler divide-ratio write strobe |
| ps_div | input | 9 | Requested divide ratio |
| cfg_we | input | 1 | Channel configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_mode | input | 3 | Mode: 0 pulse, 1 waveform, 2 event, 3 capture, 4 watchdog |
| cfg_down | input | 1 | 1 counts down, 0 counts up |
| cfg_src_pin | input | 1 | 1 selects the pin as control, 0 the logic net |
| cfg_preload | input | 16 | Preload and reload value |
| ctl_logic | input | 4 | Per-channel control from internal logic |
| ctl_pin | input | 4 | Per-channel control from pins |
| flag_clr | input | 4 | Per-channel flag clear pulses |
| rd_ch | input | 2 | Channel shown on the read port |
| rd_count | output | 16 | Running count of the read channel |
| rd_capture | output | 16 | Capture register of the read channel |
| tc_flag | output | 4 | Sticky terminal-count flags to the interrupt controller |
| wdog_out | output | 1 | Watchdog expiry output |

## Verification
The assertions check properties on every cycle:
- ticks are never back to back, and the stored ratio stays within its limits;
- a stopped pulse channel holds its count;
- an event counter does not move without an edge;
- a waveform channel lands on its preload after terminal;
- a capture edge always leaves the flag set;
- flags stay set until cleared;
- the watchdog pulse appears only in watchdog mode.

Only the bench scenarios can show the rest:
- the exact tick spacing for clamped ratios;
- cycle-accurate counts in both directions;
- the value caught by a capture;
- that the unselected control source is ignored;
- the length of the watchdog pulse and how a reload cancels it.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic [2:0] {
    MODE_PULSE = 3'd0,
    MODE_WAVE  = 3'd1,
    MODE_EVENT = 3'd2,
    MODE_CAPT  = 3'd3,
    MODE_WDOG  = 3'd4
  } ctmr_mode_e;
endpackage

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
  parameter int PS_MIN = 4,
  parameter int PS_MAX = 280,
  parameter int PSW    = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ps_we,
  input  logic [PSW-1:0] ps_div,
  output logic           tick
);
  localparam logic [PSW-1:0] MIN_V = PSW'(PS_MIN);
  localparam logic [PSW-1:0] MAX_V = PSW'(PS_MAX);

  logic [PSW-1:0] div_q;
  logic [PSW-1:0] cnt_q;
  logic           wrap;

  function automatic logic [PSW-1:0] clamp_div(input logic [PSW-1:0] v);
    if (v < MIN_V)      return MIN_V;
    else if (v > MAX_V) return MAX_V;
    else                return v;
  endfunction

  assign wrap = (cnt_q == div_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= MIN_V;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (ps_we) begin
      div_q <= clamp_div(ps_div);
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= wrap;
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  assert_div_range_R1: assert property (@(posedge clk) disable iff (rst)
    (div_q >= MIN_V) && (div_q <= MAX_V));
endmodule

// File: rtl/ctmr_ctl_edge.sv
module ctmr_ctl_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_pin,
  input  logic ctl_logic,
  input  logic ctl_pin,
  output logic level,
  output logic rise
);
  logic prev_q;

  assign level = sel_pin ? ctl_pin : ctl_logic;
  assign rise  = level & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end
endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
  import ctmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_mode,
  input  logic         cfg_down,
  input  logic         cfg_src_pin,
  input  logic [W-1:0] cfg_preload,
  input  logic         ctl_logic,
  input  logic         ctl_pin,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic [W-1:0] capture,
  output logic         tc_flag,
  output logic         wd_pulse
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [2:0]   mode_q;
  logic         down_q;
  logic         src_q;
  logic [W-1:0] pre_q;
  logic         run_q;
  logic         lvl, rise;
  logic [W-1:0] term, stepv, cnt_n;
  logic         at_term, run_n, set_flag, wd_set, cap_en;

  ctmr_ctl_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sel_pin  (src_q),
    .ctl_logic(ctl_logic),
    .ctl_pin  (ctl_pin),
    .level    (lvl),
    .rise     (rise)
  );

  assign term    = down_q ? '0 : TOP;
  assign at_term = (count == term);
  assign stepv   = down_q ? count - 1'b1 : count + 1'b1;

  always_comb begin
    cnt_n    = count;
    run_n    = run_q;
    set_flag = 1'b0;
    wd_set   = 1'b0;
    cap_en   = 1'b0;
    case (mode_q)
      MODE_PULSE: if (tick && run_q && lvl) begin
        if (at_term) begin
          set_flag = 1'b1;
          run_n    = 1'b0;
        end else cnt_n = stepv;
      end
      MODE_WAVE: if (tick && run_q && lvl) begin
        if (at_term) begin
          set_flag = 1'b1;
          cnt_n    = pre_q;
        end else cnt_n = stepv;
      end
      MODE_EVENT: if (run_q && rise) begin
        if (at_term) begin
          set_flag = 1'b1;
          cnt_n    = pre_q;
        end else cnt_n = stepv;
      end
      MODE_CAPT: begin
        if (tick && run_q) cnt_n = stepv;
        if (run_q && rise) begin
          cap_en   = 1'b1;
          set_flag = 1'b1;
        end
      end
      MODE_WDOG: if (tick && run_q) begin
        if (at_term) begin
          set_flag = 1'b1;
          wd_set   = 1'b1;
          cnt_n    = pre_q;
        end else cnt_n = stepv;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_PULSE;
      down_q   <= 1'b0;
      src_q    <= 1'b0;
      pre_q    <= '0;
      run_q    <= 1'b0;
      count    <= '0;
      capture  <= '0;
      tc_flag  <= 1'b0;
      wd_pulse <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q   <= cfg_mode;
        down_q   <= cfg_down;
        src_q    <= cfg_src_pin;
        pre_q    <= cfg_preload;
        count    <= cfg_preload;
        run_q    <= 1'b1;
        wd_pulse <= 1'b0;
      end else begin
        count <= cnt_n;
        run_q <= run_n;
        if (tick) wd_pulse <= wd_set;
        if (cap_en) capture <= count;
      end
      if (set_flag && !cfg_we) tc_flag <= 1'b1;
      else if (flag_clr)       tc_flag <= 1'b0;
    end
  end

  assert_pulse_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PULSE && !run_q && !cfg_we) |=> $stable(count));
  assert_wave_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_WAVE && run_q && tick && lvl && at_term && !cfg_we)
      |=> (count == $past(pre_q)));
  assert_event_still_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_EVENT && !rise && !cfg_we) |=> $stable(count));
  assert_capture_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_CAPT && run_q && rise && !cfg_we) |=> tc_flag);
  assert_wd_mode_R7: assert property (@(posedge clk) disable iff (rst)
    wd_pulse |-> (mode_q == MODE_WDOG));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (tc_flag && !flag_clr) |=> tc_flag);
endmodule

// File: rtl/ctmr_bank.sv
module ctmr_bank #(
  parameter int NCH    = 4,
  parameter int W      = 16,
  parameter int PS_MIN = 4,
  parameter int PS_MAX = 280,
  parameter int WD_CH  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ps_we,
  input  logic [$clog2(PS_MAX+1)-1:0]   ps_div,
  input  logic                          cfg_we,
  input  logic [$clog2(NCH)-1:0]        cfg_ch,
  input  logic [2:0]                    cfg_mode,
  input  logic                          cfg_down,
  input  logic                          cfg_src_pin,
  input  logic [W-1:0]                  cfg_preload,
  input  logic [NCH-1:0]                ctl_logic,
  input  logic [NCH-1:0]                ctl_pin,
  input  logic [NCH-1:0]                flag_clr,
  input  logic [$clog2(NCH)-1:0]        rd_ch,
  output logic [W-1:0]                  rd_count,
  output logic [W-1:0]                  rd_capture,
  output logic [NCH-1:0]                tc_flag,
  output logic                          wdog_out
);
  localparam int PSW = $clog2(PS_MAX+1);
  localparam int CW  = $clog2(NCH);

  logic           tick;
  logic [W-1:0]   cnt_a [NCH];
  logic [W-1:0]   cap_a [NCH];
  logic [NCH-1:0] wd_a;

  ctmr_prescaler #(.PS_MIN(PS_MIN), .PS_MAX(PS_MAX), .PSW(PSW)) u_ps (
    .clk   (clk),
    .rst   (rst),
    .ps_we (ps_we),
    .ps_div(ps_div),
    .tick  (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ctmr_channel #(.W(W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .cfg_we     (cfg_we && (cfg_ch == CW'(i))),
      .cfg_mode   (cfg_mode),
      .cfg_down   (cfg_down),
      .cfg_src_pin(cfg_src_pin),
      .cfg_preload(cfg_preload),
      .ctl_logic  (ctl_logic[i]),
      .ctl_pin    (ctl_pin[i]),
      .flag_clr   (flag_clr[i]),
      .count      (cnt_a[i]),
      .capture    (cap_a[i]),
      .tc_flag    (tc_flag[i]),
      .wd_pulse   (wd_a[i])
    );
  end

  assign rd_count   = cnt_a[rd_ch];
  assign rd_capture = cap_a[rd_ch];
  assign wdog_out   = wd_a[WD_CH];

  assert_wd_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_out) |-> tc_flag[WD_CH]);
endmodule

// File: tb/ctmr_bank_bench.sv
module ctmr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int WD_CH = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ps_we = 1'b0;
  logic [8:0]  ps_div = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [2:0]  cfg_mode = '0;
  logic        cfg_down = 1'b0;
  logic        cfg_src_pin = 1'b0;
  logic [15:0] cfg_preload = '0;
  logic [3:0]  ctl_logic = '0;
  logic [3:0]  ctl_pin = '0;
  logic [3:0]  flag_clr = '0;
  logic [1:0]  rd_ch = '0;
  logic [15:0] rd_count, rd_capture;
  logic [3:0]  tc_flag;
  logic        wdog_out;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  ctmr_bank u_ctmr_bank (
    .clk(clk), .rst(rst), .ps_we(ps_we), .ps_div(ps_div), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_mode(cfg_mode), .cfg_down(cfg_down),
    .cfg_src_pin(cfg_src_pin), .cfg_preload(cfg_preload),
    .ctl_logic(ctl_logic), .ctl_pin(ctl_pin), .flag_clr(flag_clr),
    .rd_ch(rd_ch), .rd_count(rd_count), .rd_capture(rd_capture),
    .tc_flag(tc_flag), .wdog_out(wdog_out)
  );

  // Behavioural expectation built from the requirements
  int          m_div, m_pcnt;
  bit          m_tick;
  int          m_mode [NCH];
  bit          m_down [NCH], m_src [NCH], m_run [NCH], m_flag [NCH], m_wd [NCH], m_prev [NCH];
  logic [15:0] m_pre [NCH], m_cnt [NCH], m_cap [NCH];

  function automatic int clamp_ratio(int v);
    if (v < 4) return 4;
    if (v > 280) return 280;
    return v;
  endfunction

  function automatic logic [15:0] step_val(logic [15:0] c, bit dn);
    return dn ? c - 16'd1 : c + 16'd1;
  endfunction

  function automatic string mode_req(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_div = 4; m_pcnt = 0; m_tick = 0;
      for (int i = 0; i < NCH; i++) begin
        m_mode[i] = 0; m_down[i] = 0; m_src[i] = 0; m_run[i] = 0; m_flag[i] = 0;
        m_wd[i] = 0; m_prev[i] = 0; m_pre[i] = '0; m_cnt[i] = '0; m_cap[i] = '0;
      end
    end else begin
      bit tk;
      tk = m_tick;
      if (ps_we) begin
        m_div = clamp_ratio(int'(ps_div)); m_pcnt = 0; m_tick = 0;
      end else begin
        m_tick = (m_pcnt == m_div - 1);
        m_pcnt = m_tick ? 0 : m_pcnt + 1;
      end
      for (int i = 0; i < NCH; i++) begin
        bit lv, rs, term, setf;
        lv = m_src[i] ? ctl_pin[i] : ctl_logic[i];
        rs = lv && !m_prev[i];
        m_prev[i] = lv;
        term = (m_cnt[i] == (m_down[i] ? 16'h0000 : 16'hFFFF));
        setf = 0;
        if (cfg_we && cfg_ch == 2'(i)) begin
          m_mode[i] = int'(cfg_mode); m_down[i] = cfg_down; m_src[i] = cfg_src_pin;
          m_pre[i] = cfg_preload; m_cnt[i] = cfg_preload; m_run[i] = 1; m_wd[i] = 0;
        end else begin
          case (m_mode[i])
            0: if (tk && m_run[i] && lv) begin
                 if (term) begin setf = 1; m_run[i] = 0; end
                 else m_cnt[i] = step_val(m_cnt[i], m_down[i]);
               end
            1: if (tk && m_run[i] && lv) begin
                 if (term) begin setf = 1; m_cnt[i] = m_pre[i]; end
                 else m_cnt[i] = step_val(m_cnt[i], m_down[i]);
               end
            2: if (m_run[i] && rs) begin
                 if (term) begin setf = 1; m_cnt[i] = m_pre[i]; end
                 else m_cnt[i] = step_val(m_cnt[i], m_down[i]);
               end
            3: begin
                 if (m_run[i] && rs) begin setf = 1; m_cap[i] = m_cnt[i]; end
                 if (tk && m_run[i]) m_cnt[i] = step_val(m_cnt[i], m_down[i]);
               end
            4: begin
                 bit wds;
                 wds = 0;
                 if (tk && m_run[i]) begin
                   if (term) begin setf = 1; wds = 1; m_cnt[i] = m_pre[i]; end
                   else m_cnt[i] = step_val(m_cnt[i], m_down[i]);
                 end
                 if (tk) m_wd[i] = wds;
               end
            default: ;
          endcase
        end
        if (setf) m_flag[i] = 1;
        else if (flag_clr[i]) m_flag[i] = 0;
      end
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %h expected %h", req, phase, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [3:0] ef;
    int c;
    c = int'(rd_ch);
    for (int i = 0; i < NCH; i++) ef[i] = m_flag[i];
    check(mode_req(m_mode[c]), "count", rd_count, m_cnt[c]);
    check("R6", "capture", rd_capture, m_cap[c]);
    check("R9", "flags", {12'h0, tc_flag}, {12'h0, ef});
    check("R7", "wdog_out", {15'h0, wdog_out}, {15'h0, m_wd[WD_CH]});
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk);
      compare();
      rd_ch = rd_ch + 2'd1;
      cfg_we = 0; ps_we = 0; flag_clr = '0;
    end
  endtask

  task automatic wr_cfg(int ch, int md, bit dn, bit sp, logic [15:0] pre);
    cfg_ch = 2'(ch); cfg_mode = 3'(md); cfg_down = dn; cfg_src_pin = sp;
    cfg_preload = pre; cfg_we = 1;
    cyc();
  endtask

  task automatic wr_ps(int v);
    ps_div = 9'(v); ps_we = 1;
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R10: reset state visible on every channel
    phase = "R10";
    cyc(4);

    // R1: ratio below the minimum clamps to 4, then back-to-back pulse count
    phase = "R1";
    wr_ps(2);
    ctl_logic = 4'b0001;
    wr_cfg(0, 0, 1, 0, 16'd30);
    cyc(60);
    wr_ps(7);
    cyc(50);
    wr_ps(400);  // clamps to 280
    cyc(600);
    wr_ps(4);

    // R2 and R3: pulse down, gated by control, stops at terminal
    phase = "R3";
    wr_cfg(0, 0, 1, 0, 16'd5);
    cyc(10);
    ctl_logic[0] = 0; cyc(12);
    ctl_logic[0] = 1; cyc(40);

    // R11: pulse counting up through 0xFFFF
    phase = "R11";
    ctl_logic[1] = 1;
    wr_cfg(1, 0, 0, 0, 16'hFFFB);
    cyc(40);

    // R4: waveform reload
    phase = "R4";
    ctl_logic[2] = 1;
    wr_cfg(2, 1, 1, 0, 16'd3);
    cyc(70);

    // R5: event counting on pin edges
    phase = "R5";
    wr_cfg(3, 2, 1, 1, 16'd2);
    for (int k = 0; k < 10; k++) begin
      ctl_pin[3] = ~ctl_pin[3]; cyc(3);
    end

    // R6: capture of the running count
    phase = "R6";
    ctl_logic[0] = 0;
    wr_cfg(0, 3, 0, 0, 16'd100);
    cyc(20);
    ctl_logic[0] = 1; cyc(9);
    ctl_logic[0] = 0; cyc(13);
    ctl_logic[0] = 1; cyc(5);

    // R9: flag clear, and set winning over clear
    phase = "R9";
    flag_clr = 4'b1111; cyc();
    cyc(4);

    // R7: watchdog expiry, then software reloads that keep it quiet
    phase = "R7";
    wr_cfg(3, 4, 1, 0, 16'd3);
    cyc(40);
    for (int k = 0; k < 8; k++) begin
      wr_cfg(3, 4, 1, 0, 16'd3); cyc(6);
    end
    cyc(30);

    // R8: only the selected control source may move the count
    phase = "R8";
    ctl_pin[1] = 0; ctl_logic[1] = 1;
    wr_cfg(1, 0, 1, 1, 16'd50);
    cyc(30);
    ctl_pin[1] = 1; ctl_logic[1] = 0;
    cyc(30);
    wr_cfg(1, 2, 0, 0, 16'd7);
    for (int k = 0; k < 8; k++) begin
      ctl_pin[1] = ~ctl_pin[1]; cyc(2);
    end

    // Mixed random traffic
    phase = "RND";
    for (int k = 0; k < 6000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) begin
        logic [15:0] p;
        int sel;
        sel = int'($urandom_range(0, 2));
        p = (sel == 0) ? 16'($urandom_range(0, 15)) :
            (sel == 1) ? 16'hFFF0 + 16'($urandom_range(0, 15)) : 16'($urandom);
        cfg_ch = 2'($urandom_range(0, 3)); cfg_mode = 3'($urandom_range(0, 4));
        cfg_down = 1'($urandom); cfg_src_pin = 1'($urandom);
        cfg_preload = p; cfg_we = 1;
      end else if (r == 3) begin
        ps_div = 9'($urandom_range(0, 40)); ps_we = 1;
      end
      if ($urandom_range(0, 9) == 0) ctl_logic = ctl_logic ^ 4'($urandom);
      if ($urandom_range(0, 9) == 0) ctl_pin = ctl_pin ^ 4'($urandom);
      if ($urandom_range(0, 19) == 0) flag_clr = 4'($urandom);
      cyc();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule